// File: doc/BRIEF.md
# PUF Response Fuse Programming Controller

This block performs the one-time configuration of a reconfigurable shift register whose stages can each pass either the true or the inverted output of the preceding flip-flop. The choice for every stage is taken from a physical unclonable function. The configuration cells are grouped so that one response source serves a whole group. A shared position enable selects the same cell in every group, so a full programming pass needs only as many steps as a group has cells.

A start request launches the pass. For each cell position, in ascending order, the controller drives a challenge select code equal to the position and raises a one-cycle challenge pulse. It then waits a fixed settle interval. After that it raises the one position enable for that position, and every group stores its response bit into the cell at that position. When the last position has been written, the controller raises a done flag. From then on the configuration is frozen until power-on reset: no later start request or response activity can change it.

The stored configuration vector is an output. Cell `g*GROUP_SIZE + p` (zero-based) belongs to group `g` and position `p`.

Top module: `puf_fuse_prog`

## Requirements
- R1: After reset, `cfg_o` is all zeros, `done_o` is 0, `pos_en_o` is all zeros and `chal_pulse_o` is 0. A zero bit means the cell passes the true flip-flop output.
- R2: A start request while idle and not yet programmed begins a pass that visits positions 0 to GROUP_SIZE-1 in ascending order, one write per position. `done_o` rises in the cycle after the last write and not before.
- R3: Each step begins with a `chal_pulse_o` that lasts exactly one cycle, with `chal_sel_o` equal to the position index. The position enable for that step is high exactly SETTLE_CYCLES+1 cycles after the pulse cycle, for one cycle.
- R4: At most one bit of `pos_en_o` is high in any cycle, and bit `p` is high only during the write of position `p`.
- R5: On the write of position `p`, cell `g*GROUP_SIZE + p` stores `puf_resp_i[g]` as sampled in the enable cycle, for every group `g`. A stored 1 selects the inverted flip-flop output and a stored 0 selects the true output.
- R6: A cell whose position has not yet been written keeps its unprogrammed value 0.
- R7: Once `done_o` is high it stays high until reset. Start requests then produce no challenge pulse and no enable, and `cfg_o` keeps its value whatever `puf_resp_i` does.
- R8: A start request that arrives while a pass is running has no effect on the order, timing or result of that pass.
- R9: `puf_resp_i` has no effect on `cfg_o` in any cycle in which no position enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| start_i | input | 1 | Request to begin the programming pass |
| puf_resp_i | input | GROUPS | One response bit per group, from the PUF units |
| chal_sel_o | output | SEL_W | Challenge select code driven to all PUF units |
| chal_pulse_o | output | 1 | One-cycle challenge pulse at the start of a step |
| pos_en_o | output | GROUP_SIZE | One-hot position enable shared by all groups |
| cfg_o | output | GROUPS*GROUP_SIZE | Stored inversion configuration, one bit per cell |
| done_o | output | 1 | Programming finished; configuration frozen |

## Verification
Two functions can fall into the same cycle. A start request can coincide with an in-flight pass, and response activity can coincide with the lock after completion. The bench raises `start_i` in the middle of a settle interval and checks that the enable order, the pulse-to-enable spacing and the final vector are those of an undisturbed pass. After `done_o`, it inverts every response the PUF model would give and requests a restart, then judges the outputs unchanged. The PUF model returns the inverted response outside the enable cycle, so a cell sampled at the wrong time shows up as a bit mismatch against the expected partial vector in that very cycle.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHAL   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_WRITE  = 3'd3,
        ST_DONE   = 3'd4
    } prog_state_e;

endpackage

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
    import fuse_prog_pkg::*;
#(
    parameter int GROUP_SIZE    = 8,
    parameter int SETTLE_CYCLES = 4,
    parameter int POS_W         = 3,
    parameter int CNT_W         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             chal_pulse_o,
    output logic [POS_W-1:0] pos_o,
    output logic             wr_en_o,
    output logic             done_o
);

    typedef struct packed {
        prog_state_e      st;
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st  = ST_CHAL;
                    seq_d.pos = '0;
                end
            end
            ST_CHAL: begin
                seq_d.st  = ST_SETTLE;
                seq_d.cnt = '0;
            end
            ST_SETTLE: begin
                if (seq_q.cnt == CNT_W'(SETTLE_CYCLES - 1)) begin
                    seq_d.st = ST_WRITE;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_WRITE: begin
                if (seq_q.pos == POS_W'(GROUP_SIZE - 1)) begin
                    seq_d.st = ST_DONE;
                end else begin
                    seq_d.st  = ST_CHAL;
                    seq_d.pos = seq_q.pos + POS_W'(1);
                end
            end
            ST_DONE: begin
                seq_d.st = ST_DONE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, pos: '0, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign chal_pulse_o = (seq_q.st == ST_CHAL);
    assign pos_o        = seq_q.pos;
    assign wr_en_o      = (seq_q.st == ST_WRITE);
    assign done_o       = (seq_q.st == ST_DONE);

endmodule

// File: rtl/fuse_prog_posdec.sv
module fuse_prog_posdec #(
    parameter int GROUP_SIZE = 8,
    parameter int POS_W      = 3
) (
    input  logic                  wr_en_i,
    input  logic [POS_W-1:0]      pos_i,
    output logic [GROUP_SIZE-1:0] pos_en_o
);

    for (genvar p = 0; p < GROUP_SIZE; p++) begin : g_pos
        assign pos_en_o[p] = wr_en_i && (pos_i == POS_W'(p));
    end

endmodule

// File: rtl/fuse_prog_cells.sv
module fuse_prog_cells #(
    parameter int GROUPS     = 8,
    parameter int GROUP_SIZE = 8,
    parameter int CELLS      = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lock_i,
    input  logic [GROUP_SIZE-1:0] pos_en_i,
    input  logic [GROUPS-1:0]     resp_i,
    output logic [CELLS-1:0]      cfg_o
);

    typedef struct packed {
        logic [CELLS-1:0] cfg;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        for (int g = 0; g < GROUPS; g++) begin
            for (int p = 0; p < GROUP_SIZE; p++) begin
                if (pos_en_i[p] && !lock_i) begin
                    cell_d.cfg[g*GROUP_SIZE + p] = resp_i[g];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign cfg_o = cell_q.cfg;

endmodule

// File: rtl/puf_fuse_prog.sv
module puf_fuse_prog #(
    parameter int GROUPS        = 8,
    parameter int GROUP_SIZE    = 8,
    parameter int SETTLE_CYCLES = 4,
    parameter int SEL_W         = $clog2(GROUP_SIZE)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [GROUPS-1:0]            puf_resp_i,
    output logic [SEL_W-1:0]             chal_sel_o,
    output logic                         chal_pulse_o,
    output logic [GROUP_SIZE-1:0]        pos_en_o,
    output logic [GROUPS*GROUP_SIZE-1:0] cfg_o,
    output logic                         done_o
);

    localparam int CELLS = GROUPS * GROUP_SIZE;
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;

    logic             wr_en;
    logic [SEL_W-1:0] pos;

    fuse_prog_seq #(
        .GROUP_SIZE   (GROUP_SIZE),
        .SETTLE_CYCLES(SETTLE_CYCLES),
        .POS_W        (SEL_W),
        .CNT_W        (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .chal_pulse_o(chal_pulse_o),
        .pos_o       (pos),
        .wr_en_o     (wr_en),
        .done_o      (done_o)
    );

    fuse_prog_posdec #(
        .GROUP_SIZE(GROUP_SIZE),
        .POS_W     (SEL_W)
    ) u_dec (
        .wr_en_i (wr_en),
        .pos_i   (pos),
        .pos_en_o(pos_en_o)
    );

    fuse_prog_cells #(
        .GROUPS    (GROUPS),
        .GROUP_SIZE(GROUP_SIZE),
        .CELLS     (CELLS)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_i  (done_o),
        .pos_en_i(pos_en_o),
        .resp_i  (puf_resp_i),
        .cfg_o   (cfg_o)
    );

    assign chal_sel_o = pos;

endmodule

// File: rtl/fuse_prog_chk.sv
module fuse_prog_chk #(
    parameter int GROUPS        = 8,
    parameter int GROUP_SIZE    = 8,
    parameter int SETTLE_CYCLES = 4,
    parameter int SEL_W         = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [SEL_W-1:0]             chal_sel_o,
    input logic                         chal_pulse_o,
    input logic [GROUP_SIZE-1:0]        pos_en_o,
    input logic [GROUPS*GROUP_SIZE-1:0] cfg_o,
    input logic                         done_o
);

    logic [15:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (chal_pulse_o) begin
            gap_q <= 16'd1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    // R4
    one_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pos_en_o));

    // R4
    pos_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pos_en_o) |-> (pos_en_o == (GROUP_SIZE'(1) << chal_sel_o)));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chal_pulse_o |=> !chal_pulse_o);

    // R3
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pos_en_o) |-> (gap_q == 16'(SETTLE_CYCLES + 1)));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && $stable(cfg_o)));

    // R7
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((pos_en_o == '0) && !chal_pulse_o));

    // R9
    idle_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_en_o == '0) |=> $stable(cfg_o));

endmodule

bind puf_fuse_prog fuse_prog_chk #(
    .GROUPS       (GROUPS),
    .GROUP_SIZE   (GROUP_SIZE),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .SEL_W        (SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chal_sel_o  (chal_sel_o),
    .chal_pulse_o(chal_pulse_o),
    .pos_en_o    (pos_en_o),
    .cfg_o       (cfg_o),
    .done_o      (done_o)
);

// File: tb/sim_puf_fuse_prog.sv
module sim_puf_fuse_prog;

    localparam int GROUPS = 8;
    localparam int GSIZE  = 8;
    localparam int SETTLE = 4;
    localparam int SEL_W  = 3;
    localparam int CELLS  = GROUPS * GSIZE;

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [GROUPS-1:0] resp;
    logic [SEL_W-1:0] sel;
    logic             pulse;
    logic [GSIZE-1:0] pos_en;
    logic [CELLS-1:0] cfg;
    logic             done;
    logic [CELLS-1:0] seed = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    // PUF model: the true response only during the enable cycle, inverted otherwise
    always_comb begin
        for (int g = 0; g < GROUPS; g++) begin
            resp[g] = seed[g*GSIZE + int'(sel)] ^ ~(|pos_en);
        end
    end

    puf_fuse_prog #(
        .GROUPS       (GROUPS),
        .GROUP_SIZE   (GSIZE),
        .SETTLE_CYCLES(SETTLE),
        .SEL_W        (SEL_W)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .puf_resp_i  (resp),
        .chal_sel_o  (sel),
        .chal_pulse_o(pulse),
        .pos_en_o    (pos_en),
        .cfg_o       (cfg),
        .done_o      (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg == '0, "R1", "cfg after reset", 64'(cfg), 64'd0);
        check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        check(pos_en == '0 && !pulse, "R1", "enables/pulse after reset",
              64'({pos_en, pulse}), 64'd0);
    endtask

    // one full programming pass; poke raises start again mid-pass (R8)
    task automatic run_program(input logic [CELLS-1:0] s, input bit poke);
        int step       = 0;
        int last_pulse = -100;
        logic [CELLS-1:0] mask = '0;
        seed = s;
        @(negedge clk);
        start = 1'b1;
        for (int c = 0; c < GSIZE*(SETTLE+2) + 4; c++) begin
            @(negedge clk);
            start = (poke && (c == 20 || c == 21)) ? 1'b1 : 1'b0;
            // R6 and R9: only written positions hold data, taken in their enable cycle
            check(cfg == (s & mask), "R6", "partial cfg", 64'(cfg), 64'(s & mask));
            if (step < GSIZE) begin
                check(done == 1'b0, "R2", "done early", 64'(done), 64'd0);
            end
            if (pulse) begin
                check(sel == SEL_W'(step), "R3", "challenge select", 64'(sel), 64'(step));
                last_pulse = c;
            end
            if (pos_en != '0) begin
                check(pos_en == GSIZE'(1) << step, "R4", "position enable",
                      64'(pos_en), 64'(GSIZE'(1) << step));
                check(c - last_pulse == SETTLE + 1, "R3", "settle spacing",
                      64'(c - last_pulse), 64'(SETTLE + 1));
                for (int g = 0; g < GROUPS; g++) begin
                    mask[g*GSIZE + step] = 1'b1;
                end
                step++;
            end
        end
        check(step == GSIZE, "R2", "positions written", 64'(step), 64'(GSIZE));
        check(done == 1'b1, "R2", "done after pass", 64'(done), 64'd1);
        check(cfg == s, "R5", "final cfg", 64'(cfg), 64'(s));
        if (poke) begin
            check(cfg == s, "R8", "cfg with mid-pass start", 64'(cfg), 64'(s));
        end
    endtask

    task automatic lock_test();
        logic [CELLS-1:0] held = cfg;
        seed = ~seed;
        @(negedge clk);
        start = 1'b1;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            start = (c % 7 == 0) ? 1'b1 : 1'b0;
            check(!pulse && pos_en == '0, "R7", "activity after done",
                  64'({pos_en, pulse}), 64'd0);
            check(cfg == held && done, "R7", "frozen cfg", 64'(cfg), 64'(held));
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        do_reset();
        run_program(64'hA5C3_0F96_3C5A_E187, 1'b0);
        lock_test();
        do_reset();
        run_program(64'h1E2D_F0B4_7788_C369, 1'b1);
        lock_test();
        report();
        $finish;
    end

endmodule